// File: doc/BRIEF.md
# Tagged Result Bus Arbiter

This block shares one result broadcast bus among eleven producers: six operand fetch buffers, two multiply/divide stations and three add stations. A producer raises its request two cycles before its result is due on the bus. The arbiter registers the request in one cycle. In the next cycle it picks a single winner by fixed priority and sends that producer a one-cycle grant pulse. The winner drives its data word during the grant cycle. In the following cycle the arbiter broadcasts that word with the winner's 4-bit source tag and a valid strobe. Consumers match the tag of the producer they wait for. They do not decode a destination address.

The producer side follows a valid/ready style. `req_i[i]` is the valid and `gnt_o[i]` is the ready. A producer holds its request and data until the cycle in which its grant is high, and that cycle completes the transfer. A request that is still high during the grant cycle is taken as part of the same handshake. A second result from the same producer must be requested from the next cycle onwards. The broadcast side has no back-pressure: every consumer must accept the bus word in the cycle it is valid.

Top module: `rbus_arbiter`

## Requirements
- R1: Producer index i maps to a fixed source tag. Fetch buffers 0..5 use tags 1..6, multiply/divide stations 0..1 (indices 6..7) use tags 8..9, and add stations 0..2 (indices 8..10) use tags 10..12. Tags 0 and 7 never appear with `bus_valid_o` high.
- R2: A request raised in cycle c with no competition produces a grant in cycle c+2. No grant ever arrives earlier than two cycles after the request is raised.
- R3: At most one bit of `gnt_o` is high in any cycle.
- R4: Among the requests waiting in a cycle, the grant goes first to the multiply/divide stations, then to the add stations, then to the fetch buffers, with the lowest index winning inside each group.
- R5: A request that is not granted stays pending. Every held request is granted within a bounded number of cycles.
- R6: In the cycle after a grant, `bus_valid_o` is 1, `bus_tag_o` carries the winner's tag and `bus_data_o` carries the word the winner drove during its grant cycle.
- R7: In the cycle after a cycle with no grant, `bus_valid_o` is 0 and `bus_tag_o` and `bus_data_o` are 0.
- R8: One request yields exactly one grant. A producer is never granted in two consecutive cycles.
- R9: While reset is asserted, all grants, the valid strobe, the tag and the data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 11 | Per-producer bus request, held until granted |
| data_i | input | 704 | Per-producer result word, 64 bits each, producer i at bits [64*i+63:64*i] |
| gnt_o | output | 11 | Per-producer one-cycle grant (outgate) pulse |
| bus_valid_o | output | 1 | Broadcast word is valid this cycle |
| bus_tag_o | output | 4 | Source tag of the broadcast word |
| bus_data_o | output | 64 | Broadcast result word |

## Verification
The bench raises all eleven requests in one cycle. A wrong priority order or a lost pending request would then show up as a grant sequence that differs from the reference, or as a fetch buffer waiting past the bound. It raises each producer alone to pin the two-cycle latency. A design that used the stale registered request again would grant the same producer twice in a row. A design off by one cycle would move the grant. Random overlapping bursts then check the tag and data pairing on the bus against a behavioural model. A wrong tag map, or data taken from the wrong cycle, gives a bus word that does not match the expected one.

// File: rtl/rbus_pkg.sv
package rbus_pkg;

  // Source tag of producer index idx: fetch buffers first, then a skipped code,
  // then multiply/divide and add stations.
  function automatic int unsigned prod_tag(int unsigned idx, int unsigned n_fetch);
    return (idx < n_fetch) ? idx + 1 : idx + 2;
  endfunction

  // Producer index that holds priority rank k (rank 0 wins).
  function automatic int unsigned rank_to_idx(int unsigned k, int unsigned n_fetch,
                                              int unsigned n_md, int unsigned n_add);
    return (k < n_md + n_add) ? n_fetch + k : k - (n_md + n_add);
  endfunction

endpackage

// File: rtl/rbus_req_stage.sv
module rbus_req_stage #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] gnt_i,
  output logic [N-1:0] elig_o
);
  logic [N-1:0] req_q;

  // A request seen during its own grant cycle is the handshake, not a new request.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i & ~gnt_i;
  end

  // The producer being granted now must not win again on its stale copy.
  assign elig_o = req_q & ~gnt_i;

endmodule

// File: rtl/rbus_prio.sv
module rbus_prio
  import rbus_pkg::*;
#(
  parameter int NUM_FETCH = 6,
  parameter int NUM_MD    = 2,
  parameter int NUM_ADD   = 3
) (
  input  logic [NUM_FETCH+NUM_MD+NUM_ADD-1:0] elig_i,
  output logic [NUM_FETCH+NUM_MD+NUM_ADD-1:0] pick_o
);
  localparam int N = NUM_FETCH + NUM_MD + NUM_ADD;

  logic [N-1:0] ord;
  logic [N-1:0] first;

  // Permute into rank order, isolate the lowest set bit, permute back.
  for (genvar k = 0; k < N; k++) begin : g_rank
    localparam int IDX = int'(rank_to_idx(k, NUM_FETCH, NUM_MD, NUM_ADD));
    assign ord[k]      = elig_i[IDX];
    assign pick_o[IDX] = first[k];
  end

  assign first = ord & ~(ord - N'(1));

endmodule

// File: rtl/rbus_drive.sv
module rbus_drive
  import rbus_pkg::*;
#(
  parameter int NUM_FETCH = 6,
  parameter int N         = 11,
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        gnt_i,
  input  logic [N*DATA_W-1:0] data_i,
  output logic                bus_valid_o,
  output logic [TAG_W-1:0]    bus_tag_o,
  output logic [DATA_W-1:0]   bus_data_o
);
  logic [TAG_W-1:0]  tag_term  [N];
  logic [DATA_W-1:0] data_term [N];
  logic [TAG_W-1:0]  tag_nx;
  logic [DATA_W-1:0] data_nx;

  for (genvar g = 0; g < N; g++) begin : g_src
    localparam logic [TAG_W-1:0] TAG_G = TAG_W'(prod_tag(g, NUM_FETCH));
    assign tag_term[g]  = gnt_i[g] ? TAG_G : '0;
    assign data_term[g] = gnt_i[g] ? data_i[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    tag_nx  = '0;
    data_nx = '0;
    for (int i = 0; i < N; i++) begin
      tag_nx  = tag_nx | tag_term[i];
      data_nx = data_nx | data_term[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_valid_o <= 1'b0;
      bus_tag_o   <= '0;
      bus_data_o  <= '0;
    end else begin
      bus_valid_o <= |gnt_i;
      bus_tag_o   <= tag_nx;
      bus_data_o  <= data_nx;
    end
  end

  p_valid_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_i) |=> bus_valid_o);
  p_idle_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|gnt_i) |=> (!bus_valid_o && bus_tag_o == '0 && bus_data_o == '0));
  p_tag_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (bus_tag_o != '0 && bus_tag_o != TAG_W'(NUM_FETCH + 1)
                     && bus_tag_o <= TAG_W'(N + 1)));

endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter
  import rbus_pkg::*;
#(
  parameter int NUM_FETCH = 6,
  parameter int NUM_MD    = 2,
  parameter int NUM_ADD   = 3,
  parameter int DATA_W    = 64,
  localparam int N        = NUM_FETCH + NUM_MD + NUM_ADD,
  localparam int TAG_W    = $clog2(N + 2)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        req_i,
  input  logic [N*DATA_W-1:0] data_i,
  output logic [N-1:0]        gnt_o,
  output logic                bus_valid_o,
  output logic [TAG_W-1:0]    bus_tag_o,
  output logic [DATA_W-1:0]   bus_data_o
);
  logic [N-1:0] elig;
  logic [N-1:0] pick;
  logic [N-1:0] gnt_q;

  rbus_req_stage #(.N(N)) i_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .gnt_i (gnt_q),
    .elig_o(elig)
  );

  rbus_prio #(.NUM_FETCH(NUM_FETCH), .NUM_MD(NUM_MD), .NUM_ADD(NUM_ADD)) i_prio (
    .elig_i(elig),
    .pick_o(pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= pick;
  end

  assign gnt_o = gnt_q;

  rbus_drive #(.NUM_FETCH(NUM_FETCH), .N(N), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gnt_i      (gnt_q),
    .data_i     (data_i),
    .bus_valid_o(bus_valid_o),
    .bus_tag_o  (bus_tag_o),
    .bus_data_o (bus_data_o)
  );

  p_one_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_no_repeat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_q[g] |=> !gnt_q[g]);
    p_grant_from_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gnt_q[g]) |-> $past(elig[g]));
  end

endmodule

// File: tb/test_rbus_arbiter.sv
module test_rbus_arbiter;
  localparam int N  = 11;
  localparam int DW = 64;
  localparam int RANK [N] = '{6, 7, 8, 9, 10, 0, 1, 2, 3, 4, 5};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*DW-1:0] data = '0;
  logic [N-1:0]  gnt;
  logic          bvalid;
  logic [3:0]    btag;
  logic [DW-1:0] bdata;

  always #10 clk = ~clk;

  rbus_arbiter i_rbus_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .data_i(data),
    .gnt_o(gnt), .bus_valid_o(bvalid), .bus_tag_o(btag), .bus_data_o(bdata)
  );

  int vectors = 0, errors = 0, cyc = 0, wd = 0;
  bit run = 0, solo = 0, done_sum = 0;
  bit want [N];
  bit active [N];
  bit gdone [N];
  bit late [N];
  int raise_cyc [N];
  int served = 0, raised = 0;
  bit seen [N];
  int exp_gnt = -1, prev_gnt = -1;
  logic [DW-1:0] prev_data = '0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int tag_of(int i);
    return (i < 6) ? i + 1 : i + 2;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!done_sum) begin
      done_sum = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
      summary();
    end
  end

  always @(negedge clk) begin
    if (run) begin
      logic [N-1:0] eg;
      int nxt;
      cyc++;
      // compare against the reference
      eg = (exp_gnt >= 0) ? (N'(1) << exp_gnt) : '0;
      chk(gnt == eg, "R4", "grant vector", DW'(gnt), DW'(eg));
      chk($countones(gnt) <= 1, "R3", "grants per cycle", DW'($countones(gnt)), 1);
      if (prev_gnt >= 0) begin
        chk(bvalid == 1'b1, "R6", "bus valid", DW'(bvalid), 1);
        chk(btag == 4'(tag_of(prev_gnt)), "R1", "bus tag", DW'(btag), DW'(tag_of(prev_gnt)));
        chk(bdata == prev_data, "R6", "bus data", bdata, prev_data);
      end else begin
        chk(bvalid == 1'b0 && btag == 4'd0 && bdata == '0, "R7", "idle bus",
            {bdata[DW-6:0], btag, bvalid}, 0);
      end
      // producers
      for (int i = 0; i < N; i++) begin
        if (gnt[i] && active[i] && !gdone[i]) begin
          gdone[i] = 1;
          chk(cyc - raise_cyc[i] >= 2, "R2", "minimum latency", DW'(cyc - raise_cyc[i]), 2);
          if (solo) chk(cyc - raise_cyc[i] == 2, "R2", "solo latency",
                        DW'(cyc - raise_cyc[i]), 2);
        end else if (gnt[i]) begin
          chk(0, "R8", $sformatf("extra grant to %0d", i), 1, 0);
        end else if (gdone[i]) begin
          req[i] = 1'b0; active[i] = 0; gdone[i] = 0; late[i] = 0; served++;
        end else if (!active[i] && want[i]) begin
          active[i] = 1; want[i] = 0; req[i] = 1'b1; raised++;
          data[i*DW +: DW] = {8'(i), 24'h5A5A00, 32'(cyc)};
          raise_cyc[i] = cyc;
        end
        if (active[i] && !gdone[i] && !late[i] && cyc - raise_cyc[i] > 60) begin
          late[i] = 1;
          chk(0, "R5", $sformatf("producer %0d starved", i), DW'(cyc - raise_cyc[i]), 60);
        end
      end
      // advance the reference
      nxt = -1;
      for (int k = 0; k < N; k++)
        if (nxt < 0 && seen[RANK[k]] && RANK[k] != exp_gnt) nxt = RANK[k];
      for (int i = 0; i < N; i++) seen[i] = req[i] && (i != exp_gnt);
      prev_gnt  = exp_gnt;
      prev_data = (exp_gnt >= 0) ? data[exp_gnt*DW +: DW] : '0;
      exp_gnt   = nxt;
    end
  end

  task automatic wait_idle();
    bit busy;
    do begin
      @(posedge clk);
      busy = 0;
      for (int i = 0; i < N; i++) busy |= active[i] | want[i];
    end while (busy);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      want[i] = 0; active[i] = 0; gdone[i] = 0; late[i] = 0; seen[i] = 0;
      raise_cyc[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(gnt == '0, "R9", "reset grants", DW'(gnt), 0);
    chk(bvalid == 1'b0, "R9", "reset valid", DW'(bvalid), 0);
    chk(btag == 4'd0, "R9", "reset tag", DW'(btag), 0);
    chk(bdata == '0, "R9", "reset data", bdata, 0);
    rst_ni = 1'b1;
    run = 1;
    // R2, R1: each producer alone
    solo = 1;
    for (int i = 0; i < N; i++) begin
      @(posedge clk); want[i] = 1;
      wait_idle();
    end
    solo = 0;
    // R4, R5: all producers at once
    @(posedge clk);
    for (int i = 0; i < N; i++) want[i] = 1;
    wait_idle();
    // R4: fetch against add, then staggered pair
    @(posedge clk); want[0] = 1; want[10] = 1;
    @(posedge clk); want[6] = 1;
    wait_idle();
    // R8: same producer re-requesting as soon as allowed
    for (int r = 0; r < 4; r++) begin
      @(posedge clk); want[7] = 1; want[3] = 1;
    end
    wait_idle();
    // mixed random bursts
    for (int c = 0; c < 400; c++) begin
      @(posedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int i = 0; i < N; i++)
        if (4'(lfsr[3:0] + 4'(i)) == 4'd0 && !active[i]) want[i] = 1;
    end
    wait_idle();
    chk(served == raised, "R5", "all requests served", DW'(served), DW'(raised));
    summary();
  end

endmodule